// File: doc/BRIEF.md
# Parallel Bus Master Sequencer

This block drives an external 8-bit parallel bus as its master. A client hands it one read or write at a time over a valid/ready request channel. The block then runs a sequence of phases on the pins: zero, one or two address-latch phases, then a setup, strobe and hold phase for each data byte. It can place the address on separate pins, share its low byte with the data pins, or share both bytes with the data pins. A 16-bit word is moved as two byte phases, low byte first, and a byte-enable line marks the high byte.

Two strobe schemes are available. In the combined scheme, one line gives the direction and a second line carries the enable pulse. In the separate scheme, a read strobe and a write strobe each have their own pin. Each control line has its own polarity, and the write and enable functions share one pin and one polarity bit. The two top address bits can be used as chip-select lines instead. When one is, its bit is driven as 0 wherever the address appears, and its select line is active for the whole transfer if the stored bit is 1. A per-pin enable hands any address or control pin back to a general-purpose value. After each transfer the stored address can step up or down by one.

Read results return on a valid/ready channel. A result is held until the client takes it, and no new request is accepted while a result is waiting, so back-pressure on the result stalls the request side. All configuration inputs must stay stable while `busy` is high.

Top module: `pbus_master`

## Requirements
- R1: `req_ready` is 1 only when no transfer is running and no read result is waiting. A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1, and `busy` is 1 from the next cycle until the last phase ends. `req_valid` pulses and `addr_load` pulses during `busy` are ignored.
- R2: The transfer runs its phases in this order, and `busy` is high for exactly as many cycles as the phases add up to.
  - Address phases: `cfg_amux` 00 adds none, 01 adds one low-latch cycle, and 10 or 11 add a low-latch cycle followed by a high-latch cycle.
  - Each byte then has setup for 1+`cfg_ws_setup` cycles, strobe for 1+`cfg_ws_strobe` cycles and hold for 1+`cfg_ws_hold` cycles.
- R3: `bus_doe` is 1 only in the following phases, and `bus_dout` carries:
  - in the low-latch phase, the effective address bits 7:0;
  - in the high-latch phase, the effective address bits 15:8;
  - in the byte phases of a write, the data byte being sent.

  In all other cycles `bus_doe` is 0 and `bus_dout` is 0.
- R4: The driven address on `pin_addr` depends on `cfg_amux`:
  - mode 00: the full effective address;
  - mode 01: effective bits 15:8 in the upper half and zeros in the lower half;
  - modes 1x: all zeros.
- R5: With `cfg_sep_strobes`=1, the read strobe on `pin_rd` is active only in the strobe cycles of a read. The write strobe on `pin_wr` is active only in the strobe cycles of a write.
- R6: With `cfg_sep_strobes`=0, `pin_rd` is the direction line. It is active throughout a read transfer and inactive otherwise. `pin_wr` is the enable strobe, active in the strobe cycles of either kind of transfer.
- R7: With `cfg_wide`=1, two bytes are moved: bits 7:0 first, then bits 15:8. `pin_be` is active in the setup, strobe and hold cycles of the second byte only.
- R8: `pin_all` is active only in the low-latch phase and `pin_alh` only in the high-latch phase.
- R9: The polarity bits in `cfg_pol` are:
  - bit 0: `pin_rd`;
  - bit 1: `pin_wr`, whether it acts as write strobe or enable;
  - bit 2: `pin_be`;
  - bit 3: both latch lines;
  - bit 4: both chip selects.

  Each pin's level is its active flag when its polarity bit is 1, and the inverse of the flag when the bit is 0.
- R10: `cfg_cs_en[0]` makes address bit 14 a chip select and `cfg_cs_en[1]` does the same for bit 15. An enabled bit reads as 0 in the effective address. `pin_cs0` and `pin_cs1` are active while `busy` is high if their select is enabled and the stored bit is 1.
- R11: `cfg_addr_pin_en[i]` decides whether `pin_addr[i]` carries the driven value or `gpio_addr[i]`. `cfg_ctl_pin_en` and `gpio_ctl` do the same for the control pins: bit 0 rd, 1 wr, 2 be, 3 all, 4 alh, 5 cs0, 6 cs1.
- R12: For a read, `bus_din` is captured at the edge that ends the last strobe cycle of each byte. `rd_data` is the high byte and low byte of the word, with the high byte 0 when `cfg_wide`=0. `rd_valid` rises as `busy` falls, and `rd_valid` and `rd_data` hold until `rd_ready` is 1.
- R13: `addr_load` writes the stored address when idle. At the end of each transfer the stored address changes according to `cfg_step`, wrapping at 16 bits:
  - 01: adds one;
  - 10: subtracts one;
  - 00 or 11: no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write word (bits 7:0 only in byte mode) |
| rd_valid | output | 1 | Read result waiting |
| rd_ready | input | 1 | Client takes the read result |
| rd_data | output | 16 | Read result |
| addr_load | input | 1 | Write the stored address |
| addr_load_val | input | 16 | New stored address |
| busy | output | 1 | Transfer in progress |
| cfg_sep_strobes | input | 1 | 1 separate read/write strobes, 0 direction plus enable |
| cfg_amux | input | 2 | Address placement mode |
| cfg_wide | input | 1 | 16-bit word mode |
| cfg_step | input | 2 | Address step after a transfer |
| cfg_cs_en | input | 2 | Chip-select use of address bits 14 and 15 |
| cfg_pol | input | 5 | Control line polarities |
| cfg_ws_setup | input | 2 | Extra setup cycles |
| cfg_ws_strobe | input | 2 | Extra strobe cycles |
| cfg_ws_hold | input | 2 | Extra hold cycles |
| cfg_addr_pin_en | input | 16 | Per address pin drive enable |
| cfg_ctl_pin_en | input | 7 | Per control pin drive enable |
| gpio_addr | input | 16 | Fallback values for address pins |
| gpio_ctl | input | 7 | Fallback values for control pins |
| bus_din | input | 8 | Data bus input |
| bus_dout | output | 8 | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |
| pin_addr | output | 16 | Address pins |
| pin_rd | output | 1 | Read strobe or direction line |
| pin_wr | output | 1 | Write strobe or enable strobe |
| pin_be | output | 1 | High-byte enable |
| pin_all | output | 1 | Low address latch strobe |
| pin_alh | output | 1 | High address latch strobe |
| pin_cs0 | output | 1 | Chip select on address bit 14 |
| pin_cs1 | output | 1 | Chip select on address bit 15 |

## Verification
Each transfer is compared against a phase-by-phase model on every pin of every cycle.

Directed transfers in each address placement mode separate three things: a missing or extra latch cycle, a wrong byte on the bus, and address bits leaking onto the dedicated pins. Combined-strobe and separate-strobe runs with both polarity settings tell the direction-line behaviour apart from the strobe behaviour.

Read data is driven correct only in the last strobe cycle and inverted in all other cycles, so a capture one edge early or late is caught. Random runs mix the following, and expose any phase-length or byte-order slip:
- wait states;
- word widths;
- stepping modes;
- chip-select use;
- pin masking;
- result back-pressure.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALO,
    PH_AHI,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  localparam logic [1:0] AM_DEMUX = 2'b00;
  localparam logic [1:0] AM_LOW   = 2'b01;

  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;

  localparam int NCS  = 2;
  localparam int NCTL = 7;
  localparam int NPOL = 5;

  localparam int CTL_RD  = 0;
  localparam int CTL_WR  = 1;
  localparam int CTL_BE  = 2;
  localparam int CTL_ALL = 3;
  localparam int CTL_ALH = 4;
  localparam int CTL_CS0 = 5;
  localparam int CTL_CS1 = 6;

  localparam int POL_RD = 0;
  localparam int POL_WR = 1;
  localparam int POL_BE = 2;
  localparam int POL_AL = 3;
  localparam int POL_CS = 4;
endpackage

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
#(
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     cfg_amux,
  input  logic           cfg_wide,
  input  logic [WSW-1:0] ws_setup,
  input  logic [WSW-1:0] ws_strobe,
  input  logic [WSW-1:0] ws_hold,
  output phase_t         phase,
  output logic           hi_byte,
  output logic           strobe_end,
  output logic           done
);
  logic [WSW-1:0] cnt;
  logic           last_byte;

  assign last_byte  = !(cfg_wide && !hi_byte);
  assign strobe_end = (phase == PH_STROBE) && (cnt == ws_strobe);
  assign done       = (phase == PH_HOLD) && (cnt == ws_hold) && last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      hi_byte <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            hi_byte <= 1'b0;
            cnt     <= '0;
            phase   <= (cfg_amux == AM_DEMUX) ? PH_SETUP : PH_ALO;
          end
        end
        PH_ALO: phase <= cfg_amux[1] ? PH_AHI : PH_SETUP;
        PH_AHI: phase <= PH_SETUP;
        PH_SETUP: begin
          if (cnt == ws_setup) begin
            cnt   <= '0;
            phase <= PH_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STROBE: begin
          if (strobe_end) begin
            cnt   <= '0;
            phase <= PH_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == ws_hold) begin
            cnt <= '0;
            if (last_byte) begin
              phase <= PH_IDLE;
            end else begin
              hi_byte <= 1'b1;
              phase   <= PH_SETUP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: an accepted request starts a transfer on the next cycle
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == PH_IDLE) |=> (phase != PH_IDLE));

  // R2: the strobe phase is only ever entered from setup
  p_strobe_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> ($past(phase) == PH_SETUP));

  // R2: a transfer only finishes out of the hold phase
  p_end_from_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) != PH_IDLE) |-> ($past(phase) == PH_HOLD));

  // R8: the high-latch phase always follows the low-latch phase
  p_ahi_after_alo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_AHI) |-> ($past(phase) == PH_ALO));
endmodule

// File: rtl/pbm_addr.sv
module pbm_addr
  import pbm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   load_val,
  input  logic            busy,
  input  logic            done,
  input  logic [1:0]      step,
  input  logic [NCS-1:0]  cs_en,
  output logic [AW-1:0]   addr_eff,
  output logic [NCS-1:0]  cs_hit
);
  localparam int CS_BASE = AW - NCS;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] cs_mask;

  assign cs_mask[CS_BASE-1:0] = '0;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_mask[CS_BASE+g] = cs_en[g];
    assign cs_hit[g]          = cs_en[g] & addr_q[CS_BASE+g];
  end

  assign addr_eff = addr_q & ~cs_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (done) begin
      if (step == STEP_INC)      addr_q <= addr_q + 1'b1;
      else if (step == STEP_DEC) addr_q <= addr_q - 1'b1;
    end else if (load && !busy) begin
      addr_q <= load_val;
    end
  end

  // R13: a load offered mid-transfer leaves the stored address alone
  p_load_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy && !done) |=> (addr_q == $past(addr_q)));

  // R13: the stored address does not move in the middle of a transfer
  p_addr_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(addr_q));
endmodule

// File: rtl/pbm_pins.sv
module pbm_pins
  import pbm_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  phase_t          phase,
  input  logic            hi_byte,
  input  logic            wr_op,
  input  logic            sep,
  input  logic [1:0]      amux,
  input  logic [NPOL-1:0] pol,
  input  logic [AW-1:0]   addr_eff,
  input  logic [NCS-1:0]  cs_hit,
  input  logic [AW-1:0]   wdata,
  input  logic [AW-1:0]   addr_pin_en,
  input  logic [AW-1:0]   gpio_addr,
  input  logic [NCTL-1:0] ctl_pin_en,
  input  logic [NCTL-1:0] gpio_ctl,
  output logic [DW-1:0]   dout,
  output logic            doe,
  output logic [AW-1:0]   pin_addr,
  output logic [NCTL-1:0] pin_ctl
);
  logic            busy, byte_ph, strobe_ph;
  logic [NCTL-1:0] act, polv;
  logic [AW-1:0]   addr_drv;

  assign busy      = (phase != PH_IDLE);
  assign strobe_ph = (phase == PH_STROBE);
  assign byte_ph   = (phase == PH_SETUP) || strobe_ph || (phase == PH_HOLD);

  always_comb begin
    act          = '0;
    act[CTL_RD]  = sep ? (strobe_ph & ~wr_op) : (busy & ~wr_op);
    act[CTL_WR]  = sep ? (strobe_ph & wr_op) : strobe_ph;
    act[CTL_BE]  = byte_ph & hi_byte;
    act[CTL_ALL] = (phase == PH_ALO);
    act[CTL_ALH] = (phase == PH_AHI);
    act[CTL_CS0] = busy & cs_hit[0];
    act[CTL_CS1] = busy & cs_hit[1];
  end

  always_comb begin
    polv          = '0;
    polv[CTL_RD]  = pol[POL_RD];
    polv[CTL_WR]  = pol[POL_WR];
    polv[CTL_BE]  = pol[POL_BE];
    polv[CTL_ALL] = pol[POL_AL];
    polv[CTL_ALH] = pol[POL_AL];
    polv[CTL_CS0] = pol[POL_CS];
    polv[CTL_CS1] = pol[POL_CS];
  end

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    logic lvl;
    assign lvl        = polv[i] ? act[i] : ~act[i];
    assign pin_ctl[i] = ctl_pin_en[i] ? lvl : gpio_ctl[i];
  end

  always_comb begin
    if (amux == AM_DEMUX)    addr_drv = addr_eff;
    else if (amux == AM_LOW) addr_drv = {addr_eff[AW-1:DW], {DW{1'b0}}};
    else                     addr_drv = '0;
  end

  for (genvar i = 0; i < AW; i++) begin : g_addr
    assign pin_addr[i] = addr_pin_en[i] ? addr_drv[i] : gpio_addr[i];
  end

  always_comb begin
    doe  = 1'b0;
    dout = '0;
    if (phase == PH_ALO) begin
      doe  = 1'b1;
      dout = addr_eff[DW-1:0];
    end else if (phase == PH_AHI) begin
      doe  = 1'b1;
      dout = addr_eff[AW-1:DW];
    end else if (byte_ph && wr_op) begin
      doe  = 1'b1;
      dout = hi_byte ? wdata[AW-1:DW] : wdata[DW-1:0];
    end
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbm_pkg::*;
#(
  parameter int DW  = 8,
  parameter int WSW = 2,
  localparam int AW = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_wdata,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_data,
  input  logic            addr_load,
  input  logic [AW-1:0]   addr_load_val,
  output logic            busy,
  input  logic            cfg_sep_strobes,
  input  logic [1:0]      cfg_amux,
  input  logic            cfg_wide,
  input  logic [1:0]      cfg_step,
  input  logic [NCS-1:0]  cfg_cs_en,
  input  logic [NPOL-1:0] cfg_pol,
  input  logic [WSW-1:0]  cfg_ws_setup,
  input  logic [WSW-1:0]  cfg_ws_strobe,
  input  logic [WSW-1:0]  cfg_ws_hold,
  input  logic [AW-1:0]   cfg_addr_pin_en,
  input  logic [NCTL-1:0] cfg_ctl_pin_en,
  input  logic [AW-1:0]   gpio_addr,
  input  logic [NCTL-1:0] gpio_ctl,
  input  logic [DW-1:0]   bus_din,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_doe,
  output logic [AW-1:0]   pin_addr,
  output logic            pin_rd,
  output logic            pin_wr,
  output logic            pin_be,
  output logic            pin_all,
  output logic            pin_alh,
  output logic            pin_cs0,
  output logic            pin_cs1
);
  phase_t          phase;
  logic            hi_byte, strobe_end, done, accept;
  logic            wr_op, rd_pend;
  logic [AW-1:0]   wdata_q, rbuf;
  logic [AW-1:0]   addr_eff;
  logic [NCS-1:0]  cs_hit;
  logic [NCTL-1:0] pin_ctl;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy && !rd_pend;
  assign accept    = req_valid && req_ready;
  assign rd_valid  = rd_pend;
  assign rd_data   = rbuf;

  pbm_seq #(.WSW(WSW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .cfg_amux   (cfg_amux),
    .cfg_wide   (cfg_wide),
    .ws_setup   (cfg_ws_setup),
    .ws_strobe  (cfg_ws_strobe),
    .ws_hold    (cfg_ws_hold),
    .phase      (phase),
    .hi_byte    (hi_byte),
    .strobe_end (strobe_end),
    .done       (done)
  );

  pbm_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_load),
    .load_val (addr_load_val),
    .busy     (busy),
    .done     (done),
    .step     (cfg_step),
    .cs_en    (cfg_cs_en),
    .addr_eff (addr_eff),
    .cs_hit   (cs_hit)
  );

  pbm_pins #(.DW(DW)) u_pins (
    .phase       (phase),
    .hi_byte     (hi_byte),
    .wr_op       (wr_op),
    .sep         (cfg_sep_strobes),
    .amux        (cfg_amux),
    .pol         (cfg_pol),
    .addr_eff    (addr_eff),
    .cs_hit      (cs_hit),
    .wdata       (wdata_q),
    .addr_pin_en (cfg_addr_pin_en),
    .gpio_addr   (gpio_addr),
    .ctl_pin_en  (cfg_ctl_pin_en),
    .gpio_ctl    (gpio_ctl),
    .dout        (bus_dout),
    .doe         (bus_doe),
    .pin_addr    (pin_addr),
    .pin_ctl     (pin_ctl)
  );

  assign pin_rd  = pin_ctl[CTL_RD];
  assign pin_wr  = pin_ctl[CTL_WR];
  assign pin_be  = pin_ctl[CTL_BE];
  assign pin_all = pin_ctl[CTL_ALL];
  assign pin_alh = pin_ctl[CTL_ALH];
  assign pin_cs0 = pin_ctl[CTL_CS0];
  assign pin_cs1 = pin_ctl[CTL_CS1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_op   <= 1'b0;
      wdata_q <= '0;
      rbuf    <= '0;
      rd_pend <= 1'b0;
    end else begin
      if (accept) begin
        wr_op   <= req_write;
        wdata_q <= req_wdata;
        rbuf    <= '0;
      end
      if (strobe_end && !wr_op) begin
        if (hi_byte) rbuf[AW-1:DW] <= bus_din;
        else         rbuf[DW-1:0]  <= bus_din;
      end
      if (done && !wr_op)          rd_pend <= 1'b1;
      else if (rd_pend && rd_ready) rd_pend <= 1'b0;
    end
  end

  // R12: a waiting read result holds its value until it is taken
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R1: no request is taken while a transfer runs or a result waits
  p_no_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || rd_valid) |-> !accept);

  // R12: a read result appears only as a read transfer finishes
  p_rd_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $fell(busy));
endmodule

// File: tb/sim_pbus_master.sv
module sim_pbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, rd_ready = 0, addr_load = 0;
  logic        req_ready, rd_valid, busy, bus_doe;
  logic [15:0] req_wdata = 0, addr_load_val = 0, rd_data, pin_addr;
  logic        cfg_sep_strobes = 1, cfg_wide = 0;
  logic [1:0]  cfg_amux = 0, cfg_step = 0, cfg_cs_en = 0;
  logic [4:0]  cfg_pol = 5'h1f;
  logic [1:0]  cfg_ws_setup = 0, cfg_ws_strobe = 0, cfg_ws_hold = 0;
  logic [15:0] cfg_addr_pin_en = 16'hffff, gpio_addr = 0;
  logic [6:0]  cfg_ctl_pin_en = 7'h7f, gpio_ctl = 0;
  logic [7:0]  bus_din = 0, bus_dout;
  logic        pin_rd, pin_wr, pin_be, pin_all, pin_alh, pin_cs0, pin_cs1;

  always #2.5 clk = ~clk;

  pbus_master u0 (.*);

  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;
  logic [15:0] m_addr = 0;
  bit          cur_wr;
  logic [15:0] cur_wd;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // phase codes: 0 idle, 1 low latch, 2 high latch, 3 setup, 4 strobe, 5 hold
  function automatic void model(input int k, output int ph, output int b, output bit last_st);
    int na, len, j, r;
    na  = (cfg_amux == 2'b00) ? 0 : ((cfg_amux == 2'b01) ? 1 : 2);
    len = 3 + cfg_ws_setup + cfg_ws_strobe + cfg_ws_hold;
    last_st = 0;
    b = 0;
    if (k < na) begin
      ph = (k == 0) ? 1 : 2;
    end else begin
      j = k - na;
      b = j / len;
      r = j % len;
      if (r < 1 + cfg_ws_setup)                      ph = 3;
      else if (r < 2 + cfg_ws_setup + cfg_ws_strobe) ph = 4;
      else                                           ph = 5;
      last_st = (r == 1 + cfg_ws_setup + cfg_ws_strobe);
    end
  endfunction

  function automatic int xfer_len();
    int na;
    na = (cfg_amux == 2'b00) ? 0 : ((cfg_amux == 2'b01) ? 1 : 2);
    return na + (cfg_wide ? 2 : 1) * (3 + cfg_ws_setup + cfg_ws_strobe + cfg_ws_hold);
  endfunction

  function automatic logic lvl(input logic a, input logic p, input logic en, input logic g);
    return en ? (p ? a : ~a) : g;
  endfunction

  task automatic check_pins(input int ph, input int b);
    logic [15:0] af, drv, exp_addr;
    logic bsy, byp, stp, rd_a, wr_a;
    logic [7:0] e_dout;
    logic e_doe;
    af = m_addr;
    if (cfg_cs_en[0]) af[14] = 1'b0;
    if (cfg_cs_en[1]) af[15] = 1'b0;
    bsy = (ph != 0);
    stp = (ph == 4);
    byp = (ph >= 3);
    rd_a = cfg_sep_strobes ? (stp && !cur_wr) : (bsy && !cur_wr);
    wr_a = cfg_sep_strobes ? (stp && cur_wr) : stp;
    if (cfg_amux == 2'b00)      drv = af;
    else if (cfg_amux == 2'b01) drv = {af[15:8], 8'h00};
    else                        drv = 16'h0000;
    exp_addr = (drv & cfg_addr_pin_en) | (gpio_addr & ~cfg_addr_pin_en);
    chk("R4 R11 address pins", pin_addr, exp_addr);
    e_doe = 0;
    e_dout = 0;
    if (ph == 1)                  begin e_doe = 1; e_dout = af[7:0];  end
    else if (ph == 2)             begin e_doe = 1; e_dout = af[15:8]; end
    else if (byp && cur_wr)       begin e_doe = 1; e_dout = b ? cur_wd[15:8] : cur_wd[7:0]; end
    chk("R3 bus_doe", bus_doe, e_doe);
    chk("R3 bus_dout", bus_dout, e_dout);
    chk("R5 R6 R9 pin_rd", pin_rd, lvl(rd_a, cfg_pol[0], cfg_ctl_pin_en[0], gpio_ctl[0]));
    chk("R5 R6 R9 pin_wr", pin_wr, lvl(wr_a, cfg_pol[1], cfg_ctl_pin_en[1], gpio_ctl[1]));
    chk("R7 pin_be", pin_be, lvl(byp && b == 1, cfg_pol[2], cfg_ctl_pin_en[2], gpio_ctl[2]));
    chk("R8 pin_all", pin_all, lvl(ph == 1, cfg_pol[3], cfg_ctl_pin_en[3], gpio_ctl[3]));
    chk("R8 pin_alh", pin_alh, lvl(ph == 2, cfg_pol[3], cfg_ctl_pin_en[4], gpio_ctl[4]));
    chk("R10 pin_cs0", pin_cs0,
        lvl(bsy && cfg_cs_en[0] && m_addr[14], cfg_pol[4], cfg_ctl_pin_en[5], gpio_ctl[5]));
    chk("R10 pin_cs1", pin_cs1,
        lvl(bsy && cfg_cs_en[1] && m_addr[15], cfg_pol[4], cfg_ctl_pin_en[6], gpio_ctl[6]));
  endtask

  task automatic load_addr(input logic [15:0] v);
    @(negedge clk);
    addr_load = 1;
    addr_load_val = v;
    @(negedge clk);
    addr_load = 0;
    m_addr = v;
  endtask

  task automatic transfer(input bit wr, input logic [15:0] wd, input logic [15:0] rdv, input bit poke);
    int n, ph, b, d;
    bit ls;
    logic [15:0] exp_rd;
    n = xfer_len();
    @(negedge clk);
    req_valid = 1;
    req_write = wr;
    req_wdata = wd;
    cur_wr = wr;
    cur_wd = wd;
    #1 chk("R1 req_ready before accept", req_ready, 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      model(k, ph, b, ls);
      req_valid = poke && (k == 1);
      req_write = ~wr;
      req_wdata = ~wd;
      addr_load = poke && (k == 1);
      addr_load_val = ~m_addr;
      bus_din = ls ? (b ? rdv[15:8] : rdv[7:0]) : ~(b ? rdv[15:8] : rdv[7:0]);
      #1;
      chk("R1 R2 busy during transfer", busy, 1);
      if (poke && k == 1) chk("R1 req_ready low while busy", req_ready, 0);
      check_pins(ph, b);
    end
    @(negedge clk);
    req_valid = 0;
    addr_load = 0;
    if (cfg_step == 2'b01)      m_addr = m_addr + 16'd1;
    else if (cfg_step == 2'b10) m_addr = m_addr - 16'd1;
    #1;
    chk("R2 busy falls after last phase", busy, 0);
    check_pins(0, 0);
    if (!wr) begin
      exp_rd = cfg_wide ? rdv : {8'h00, rdv[7:0]};
      chk("R12 rd_valid after read", rd_valid, 1);
      chk("R12 rd_data", rd_data, exp_rd);
      chk("R1 R12 req_ready low with result waiting", req_ready, 0);
      d = $urandom % 3;
      repeat (d) begin
        @(negedge clk);
        #1;
        chk("R12 rd_valid held", rd_valid, 1);
        chk("R12 rd_data held", rd_data, exp_rd);
        chk("R1 R2 no new transfer", busy, 0);
      end
      rd_ready = 1;
      @(negedge clk);
      rd_ready = 0;
      #1;
      chk("R12 rd_valid cleared when taken", rd_valid, 0);
      chk("R1 req_ready after result taken", req_ready, 1);
    end else begin
      chk("R12 no result after write", rd_valid, 0);
      chk("R1 req_ready after write", req_ready, 1);
    end
    if (poke) begin
      @(negedge clk);
      #1;
      chk("R1 poked request ignored", busy, 0);
      check_pins(0, 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // reset state
    chk("R1 busy after reset", busy, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    chk("R12 rd_valid after reset", rd_valid, 0);
    cur_wr = 0;
    cur_wd = 0;
    check_pins(0, 0);

    // demux, separate strobes, byte mode
    load_addr(16'h1234);
    transfer(1, 16'h00a7, 16'h0000, 0);
    transfer(0, 16'h0000, 16'h005c, 0);

    // low byte shared, word mode, wait states (R7, R2)
    cfg_amux = 2'b01; cfg_wide = 1;
    cfg_ws_setup = 1; cfg_ws_strobe = 2; cfg_ws_hold = 3;
    transfer(1, 16'hbeef, 16'h0000, 0);
    transfer(0, 16'h0000, 16'h3c96, 0);

    // both bytes shared, combined strobes, chip selects, low-active lines (R6 R9 R10)
    cfg_amux = 2'b10; cfg_sep_strobes = 0; cfg_cs_en = 2'b11; cfg_pol = 5'b01010;
    cfg_ws_setup = 0; cfg_ws_strobe = 1; cfg_ws_hold = 0;
    load_addr(16'hc0f0);
    transfer(1, 16'h1357, 16'h0000, 0);
    transfer(0, 16'h0000, 16'h8421, 0);
    cfg_cs_en = 2'b01;
    load_addr(16'h4aa5);
    cfg_amux = 2'b11; // treated as both bytes shared (R2)
    transfer(0, 16'h0000, 16'h55aa, 0);

    // requests and loads during busy are ignored (R1 R13)
    cfg_amux = 2'b00; cfg_sep_strobes = 1; cfg_cs_en = 0; cfg_pol = 5'h1f; cfg_wide = 0;
    cfg_step = 2'b01;
    load_addr(16'h0100);
    transfer(1, 16'h0042, 16'h0000, 1);
    transfer(0, 16'h0000, 16'h0017, 1);

    // wrap on increment and decrement (R13)
    load_addr(16'hffff);
    transfer(1, 16'h0011, 16'h0000, 0);
    cfg_step = 2'b10;
    transfer(1, 16'h0022, 16'h0000, 0);
    cfg_step = 2'b11;
    transfer(1, 16'h0033, 16'h0000, 0);

    // pin masking (R11)
    cfg_addr_pin_en = 16'h00ff; cfg_ctl_pin_en = 7'b0101010;
    gpio_addr = 16'ha5c3; gpio_ctl = 7'b1100110;
    transfer(1, 16'h0044, 16'h0000, 0);
    transfer(0, 16'h0000, 16'h0099, 0);

    // random mix
    for (int t = 0; t < 160; t++) begin
      cfg_sep_strobes = $urandom % 2;
      cfg_amux        = $urandom % 4;
      cfg_wide        = $urandom % 2;
      cfg_step        = $urandom % 4;
      cfg_cs_en       = $urandom % 4;
      cfg_pol         = $urandom % 32;
      cfg_ws_setup    = $urandom % 4;
      cfg_ws_strobe   = $urandom % 4;
      cfg_ws_hold     = $urandom % 4;
      cfg_addr_pin_en = ($urandom % 2) ? 16'hffff : 16'($urandom);
      cfg_ctl_pin_en  = ($urandom % 2) ? 7'h7f : 7'($urandom);
      gpio_addr       = 16'($urandom);
      gpio_ctl        = 7'($urandom);
      if ($urandom % 4 == 0) load_addr(($urandom % 2) ? 16'hfffe : 16'($urandom));
      transfer($urandom % 2, 16'($urandom), 16'($urandom), ($urandom % 8) == 0);
    end

    finish_run();
  end
endmodule